// File: doc/BRIEF.md
# ROM Bank Access Timing Controller

This block sits between an internal read requester and one external ROM or SRAM bank. A single 32-bit setup word chooses where the bank sits in the address map, and how many clock cycles a read takes. It also chooses whether the bank supports fast reads inside a page, and how large that page is.

When a request falls inside the bank's window, the block asserts chip select and output enable. It presents the latched address and holds the requester off for the programmed number of cycles. In the final cycle it signals ready, and the memory's data is passed to the requester in that same cycle.

A read that stays inside the page of the previous completed read uses the shorter page time. Any other read uses the full random access time. Requests outside the window, and requests to a bank whose access code is off, are never answered. The requester is expected to hold its request until it sees ready.

Top module: `rom_bank_ctrl`

## Requirements
- R1: After reset the setup word reads 0x00000060, chip select and output enable are high (inactive) and ready is low.
- R2: A setup write replaces the whole word. The field layout is: bits [1:0] page size, bits [3:2] page time code, bits [6:4] random time code, bits [19:10] window start, and bits [29:20] window end. Both window fields count in units of 65536 bytes.
- R3: A request hits only when its byte address is at least start×65536 and strictly below end×65536.
- R4: For random time codes 1 to 6, chip select and output enable stay low for code+1 consecutive cycles, and ready is high in the last of them.
- R5: With random time code 0 or 7, the bank is off: no chip select and no ready for any address.
- R6: A request that misses the window produces no chip select and no ready, and does not change the remembered page.
- R7: Ready is high for exactly one cycle per access, and read data equals the memory data in that cycle.
- R8: With page size code 0, every access uses the random time.
- R9: Page size codes 1, 2 and 3 give pages of 4, 8 and 16 words (words of DATA_W bits). An access inside the same aligned page as the previous completed access takes the page time. Page code 0 gives 5 cycles; page codes 1 to 3 give code+1 cycles.
- R10: The first access after reset or after any setup write uses the random time, as does any access that leaves the remembered page.
- R11: Chip select and output enable change together, and the memory address stays equal to the request address for the whole access.
- R12: After each ready, chip select is high for at least one cycle before the next access starts, even if a request is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load the setup word |
| cfg_wdata | input | 32 | New setup word |
| cfg_q | output | 32 | Current setup word |
| req_valid | input | 1 | Read request, held until ready |
| req_addr | input | 26 | Request byte address |
| req_ready | output | 1 | One-cycle completion strobe |
| rd_data | output | DATA_W | Read data, valid with ready |
| mem_cs_n | output | 1 | Bank chip select, active low |
| mem_oe_n | output | 1 | Bank output enable, active low |
| mem_addr | output | 26 | Byte address to the bank |
| mem_data | input | DATA_W | Data from the bank |

## Verification
The bench builds the block with DATA_W at 32, so a word is 4 bytes. The three page sizes then become 16-, 32- and 64-byte blocks, and their boundaries sit at addresses that are easy to step across. With the 26-bit address, both window edges can be placed at any 64 KB boundary. This lets the bench probe the last word below the window end and the first word past it. A behavioural reference built from integers predicts chip select, ready and read data on every cycle. This covers held requests, misses placed between page hits, and setup rewrites that must make the block forget the remembered page.

// File: rtl/rbk_pkg.sv
// Shared layout and timing decode for the ROM bank controller.
// Assumes a 10-bit window pointer scaled by 64 KB, giving a 26-bit byte address.
package rbk_pkg;
    localparam int PTR_W      = 10;
    localparam int UNIT_SHIFT = 16;
    localparam int ADDR_W     = PTR_W + UNIT_SHIFT;
    localparam int LAT_W      = 3;
    localparam logic [31:0] CFG_RESET = 32'h0000_0060;

    typedef struct packed {
        logic [1:0]       spare;
        logic [PTR_W-1:0] end_ptr;
        logic [PTR_W-1:0] start_ptr;
        logic [2:0]       pad;
        logic [2:0]       rand_code;
        logic [1:0]       page_code;
        logic [1:0]       page_size;
    } bank_cfg_t;

    function automatic logic bank_on(input logic [2:0] code);
        return (code != 3'd0) && (code != 3'd7);
    endfunction

    function automatic logic [LAT_W-1:0] rand_cycles(input logic [2:0] code);
        return code + 3'd1;
    endfunction

    function automatic logic [LAT_W-1:0] page_cycles(input logic [1:0] code);
        return (code == 2'd0) ? 3'd5 : ({1'b0, code} + 3'd1);
    endfunction
endpackage

// File: rtl/rbk_cfg_reg.sv
// Holds the bank setup word. Assumes whole-word writes only.
module rbk_cfg_reg
    import rbk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we,
    input  logic [31:0] wdata,
    output bank_cfg_t cfg
);
    // Load the new word on write, the fixed value on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  cfg <= bank_cfg_t'(CFG_RESET);
        else if (we) cfg <= bank_cfg_t'(wdata);
    end
endmodule

// File: rtl/rbk_window.sv
// Decides whether a byte address lies in the bank window.
// Assumes an empty window whenever end is not above start.
module rbk_window
    import rbk_pkg::*;
(
    input  bank_cfg_t         cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [ADDR_W-1:0] lo_addr;
    logic [ADDR_W-1:0] hi_addr;

    // Scale the pointers to byte addresses and compare.
    always_comb begin
        lo_addr = {cfg.start_ptr, {UNIT_SHIFT{1'b0}}};
        hi_addr = {cfg.end_ptr, {UNIT_SHIFT{1'b0}}};
        hit     = (addr >= lo_addr) && (addr < hi_addr);
    end
endmodule

// File: rtl/rbk_page_track.sv
// Remembers the address of the last launched access and reports whether
// a new address shares its aligned page. Assumes the caller clears it on
// every setup write, so the page size cannot change under a valid entry.
module rbk_page_track
    import rbk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              launch,
    input  logic [1:0]        page_size,
    input  logic [ADDR_W-1:0] addr,
    output logic              same_page
);
    localparam int OFS_W = $clog2(DATA_W / 8);

    logic              held;
    logic [ADDR_W-1:0] last_addr;
    logic [4:0]        blk_shift;

    // Compare the address bits above the page offset.
    always_comb begin
        blk_shift = 5'(OFS_W) + 5'd1 + {3'b000, page_size};
        same_page = held && (page_size != 2'd0)
                 && (((addr ^ last_addr) >> blk_shift) == '0);
    end

    // Record each launch; a setup write forgets the page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held      <= 1'b0;
            last_addr <= '0;
        end else if (clear) begin
            held      <= 1'b0;
        end else if (launch) begin
            held      <= 1'b1;
            last_addr <= addr;
        end
    end

    AST_CLEAR_FORGETS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !same_page); // R10
endmodule

// File: rtl/rbk_seq.sv
// Access sequencer: holds the bank selected for a loaded number of cycles
// and raises ready in the last one. Assumes lat is at least 2.
module rbk_seq
    import rbk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [LAT_W-1:0]  lat,
    input  logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              ready,
    output logic [ADDR_W-1:0] addr_q
);
    logic [LAT_W-1:0] left;

    // Ready marks the final cycle of an access.
    always_comb ready = busy && (left == '0);

    // Count the access down and latch its address at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            left   <= '0;
            addr_q <= '0;
        end else if (busy) begin
            if (left == '0) busy <= 1'b0;
            else            left <= left - 1'b1;
        end else if (launch) begin
            busy   <= 1'b1;
            left   <= lat - 1'b1;
            addr_q <= addr;
        end
    end

    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready); // R7
    AST_GAP_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !busy); // R12
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ready) |=> $stable(addr_q)); // R11
endmodule

// File: rtl/rom_bank_ctrl.sv
// Single ROM/SRAM bank timing controller. Decodes the window, picks random
// or page timing, and sequences chip select, output enable and ready.
// Assumes the requester holds req_valid and req_addr until req_ready.
module rom_bank_ctrl
    import rbk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_q,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_data
);
    bank_cfg_t        cfg;
    logic             hit;
    logic             same_page;
    logic             busy;
    logic             ready;
    logic             launch;
    logic [LAT_W-1:0] lat;

    rbk_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg)
    );

    rbk_window u_win (.cfg(cfg), .addr(req_addr), .hit(hit));

    rbk_page_track #(.DATA_W(DATA_W)) u_page (
        .clk(clk), .rst_n(rst_n), .clear(cfg_we), .launch(launch),
        .page_size(cfg.page_size), .addr(req_addr), .same_page(same_page)
    );

    // Start only from idle, on an enabled bank, inside the window.
    always_comb begin
        launch = !busy && req_valid && hit && bank_on(cfg.rand_code);
        lat    = same_page ? page_cycles(cfg.page_code) : rand_cycles(cfg.rand_code);
    end

    rbk_seq u_seq (
        .clk(clk), .rst_n(rst_n), .launch(launch), .lat(lat), .addr(req_addr),
        .busy(busy), .ready(ready), .addr_q(mem_addr)
    );

    // Drive the bank strobes and the requester side.
    always_comb begin
        cfg_q     = cfg;
        mem_cs_n  = !busy;
        mem_oe_n  = !busy;
        req_ready = ready;
        rd_data   = mem_data;
    end

    AST_OFF_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !bank_on(cfg.rand_code)) |=> mem_cs_n); // R5
    AST_MISS_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !hit) |=> mem_cs_n); // R6
    AST_READY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_cs_n && !mem_oe_n)); // R11
endmodule

// File: tb/rom_bank_ctrl_bench.sv
module rom_bank_ctrl_bench;
    localparam int DW = 32;
    localparam int AW = 26;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_q;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic [DW-1:0] rd_data;
    logic          mem_cs_n, mem_oe_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    assign mem_data = {6'h15, mem_addr};

    rom_bank_ctrl #(.DATA_W(DW)) u_rom_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_q(cfg_q), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rd_data(rd_data), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    bit          m_busy;
    int          m_left;
    int          m_addr;
    bit          m_pg_ok;
    int          m_pg_addr;
    logic [31:0] m_cfg;

    function automatic bit m_on(logic [31:0] c);
        return c[6:4] != 0 && c[6:4] != 7;
    endfunction
    function automatic bit m_hit(logic [31:0] c, int a);
        return a >= int'(c[19:10]) * 65536 && a < int'(c[29:20]) * 65536;
    endfunction
    function automatic bit m_same(logic [31:0] c, int a);
        int pb = (DW / 8) * (2 << c[1:0]);
        return m_pg_ok && c[1:0] != 0 && (a / pb) == (m_pg_addr / pb);
    endfunction
    function automatic int m_lat(logic [31:0] c, int a);
        if (m_same(c, a)) return (c[3:2] == 0) ? 5 : int'(c[3:2]) + 1;
        return int'(c[6:4]) + 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_left = 0; m_addr = 0; m_pg_ok = 0; m_pg_addr = 0;
            m_cfg = 32'h60;
        end else begin
            logic [31:0] c;
            c = m_cfg;
            if (m_busy) begin
                if (m_left == 1) m_busy = 0;
                else m_left = m_left - 1;
            end else if (req_valid && m_on(c) && m_hit(c, int'(req_addr))) begin
                m_busy = 1;
                m_left = m_lat(c, int'(req_addr));
                m_addr = int'(req_addr);
                if (!cfg_we) begin
                    m_pg_ok = 1;
                    m_pg_addr = int'(req_addr);
                end
            end
            if (cfg_we) begin
                m_cfg = cfg_wdata;
                m_pg_ok = 0;
            end
        end
    end

    // Compare every cycle, away from the active edge.
    always begin
        @(negedge clk); #3;
        if (rst_n) begin
            chk(mem_cs_n == !m_busy, "R4 R5 R6 R12 chip select", mem_cs_n, !m_busy);
            chk(mem_oe_n == mem_cs_n, "R11 output enable", mem_oe_n, mem_cs_n);
            chk(req_ready == (m_busy && m_left == 1), "R4 R7 ready", req_ready, m_busy && m_left == 1);
            if (m_busy)
                chk(int'(mem_addr) == m_addr, "R11 address", mem_addr, m_addr);
            if (req_ready)
                chk(rd_data == {6'h15, m_addr[AW-1:0]}, "R7 data", rd_data, {6'h15, m_addr[AW-1:0]});
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [31:0] mk(int e, int s, int rc, int pc, int ps);
        return (32'(e) << 20) | (32'(s) << 10) | (32'(rc) << 4) | (32'(pc) << 2) | 32'(ps);
    endfunction

    task automatic wr_cfg(input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 0;
        #3 chk(cfg_q == w, "R2 setup readback", cfg_q, w);
    endtask

    // exp == 0 means no answer is allowed.
    task automatic rd(input int a, input int exp, input string req);
        int cnt = 0;
        bit got = 0;
        @(negedge clk);
        req_addr = AW'(a); req_valid = 1;
        for (int i = 0; i < 12 && !got; i++) begin
            @(negedge clk); #3;
            cnt++;
            if (req_ready) got = 1;
        end
        @(negedge clk);
        req_valid = 0;
        if (exp == 0) chk(!got, req, got, 0);
        else chk(got && cnt == exp, req, got ? cnt : -1, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #3;
        chk(cfg_q == 32'h60, "R1 reset word", cfg_q, 32'h60);
        chk(mem_cs_n && mem_oe_n, "R1 strobes idle", {mem_cs_n, mem_oe_n}, 2'b11);
        chk(!req_ready, "R1 ready low", req_ready, 0);
        rd(24'h40_0000, 0, "R3 empty window after reset");

        // Normal mode, 7-cycle random time, window 0x400000..0x5FFFFF
        wr_cfg(mk(12'h060, 12'h040, 6, 0, 0));
        rd(32'h40_0000, 7, "R3 R4 window start");
        rd(32'h5F_FFFC, 7, "R3 last word inside");
        rd(32'h5F_FFF8, 7, "R8 same page still random");
        rd(32'h60_0000, 0, "R3 R6 window end excluded");
        rd(32'h3F_FFFC, 0, "R3 R6 below start");

        wr_cfg(mk(12'h060, 12'h040, 1, 0, 0));
        rd(32'h40_0100, 2, "R4 code 1");
        wr_cfg(mk(12'h060, 12'h040, 3, 0, 0));
        rd(32'h40_0100, 4, "R4 code 3");

        wr_cfg(mk(12'h060, 12'h040, 0, 1, 1));
        rd(32'h40_0000, 0, "R5 code 0 off");
        wr_cfg(mk(12'h060, 12'h040, 7, 1, 1));
        rd(32'h40_0000, 0, "R5 code 7 off");

        // 4-word pages, page code 1, random code 4
        wr_cfg(mk(12'h060, 12'h040, 4, 1, 1));
        rd(32'h40_0000, 5, "R10 first after write");
        rd(32'h40_0004, 2, "R9 page hit");
        rd(32'h40_000C, 2, "R9 last word of page");
        rd(32'h40_0010, 5, "R10 leaves page");
        rd(32'h40_0014, 2, "R9 new page hit");
        rd(32'h70_0000, 0, "R6 miss between");
        rd(32'h40_0018, 2, "R6 miss kept page");
        wr_cfg(mk(12'h060, 12'h040, 4, 1, 1));
        rd(32'h40_001C, 5, "R10 rewrite forgets page");

        // 8-word pages, page code 3
        wr_cfg(mk(12'h060, 12'h040, 4, 3, 2));
        rd(32'h40_0000, 5, "R10 first 8-word");
        rd(32'h40_001C, 4, "R9 8-word hit code 3");
        rd(32'h40_0020, 5, "R10 8-word boundary");

        // 16-word pages, page code 0 (5 cycles), random code 2
        wr_cfg(mk(12'h060, 12'h040, 2, 0, 3));
        rd(32'h40_0000, 3, "R10 first 16-word");
        rd(32'h40_003C, 5, "R9 page code 0");
        rd(32'h40_0040, 3, "R10 16-word boundary");
        wr_cfg(mk(12'h060, 12'h040, 5, 2, 3));
        rd(32'h40_0080, 6, "R10 first after write");
        rd(32'h40_0084, 3, "R9 page code 2");

        // Held request: normal mode, 2-cycle access
        wr_cfg(mk(12'h060, 12'h040, 1, 0, 0));
        begin
            int rdy = 0;
            int idle = 0;
            @(negedge clk);
            req_addr = 26'h40_0200; req_valid = 1;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk); #3;
                if (req_ready) rdy++;
                if (mem_cs_n) idle++;
            end
            @(negedge clk);
            req_valid = 0;
            chk(rdy == 3, "R12 readies while held", rdy, 3);
            chk(idle == 2, "R12 idle gaps", idle, 2);
        end

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule